// File: doc/BRIEF.md
# ADC Output Test-Pattern Formatter

This block sits between the sample word of a data converter core and the output pins. On every sample strobe it registers a 13-bit output word: the overflow flag in the top bit and the 12 sample bits below it. In normal operation the sample can be reshaped by three optional transforms. The first converts offset binary to two's complement. The second is a bit randomizer. The third inverts every other bit. Each transform has its own enable.

For checking the digital interface in circuit, a 3-bit select forces the whole word, including the overflow bit, to a known pattern. The patterns are constant zeros, constant ones, a whole-word toggle, and a checkerboard whose two phases swap on every strobe. A selected pattern always wins over the transforms. A single disable bit turns off the output enables of all 13 data pins and of the clock output.

Top module: `adc_out_formatter`

## Requirements
- R1: While `rst_n` is low, `dout`, `dout_oe` and `clkout_oe` are all zero.
- R2: With `pat_sel` = 000 and all transforms off, the clock edge that samples `smp_vld` high loads `dout` with `{smp_ovf, smp_data}`. Bit 12 is the overflow flag. `dout` holds its value on edges where `smp_vld` is low. The overflow bit is never altered by the transforms.
- R3: With `pat_sel` = 001, a strobe loads `dout` with all zeros.
- R4: With `pat_sel` = 010, a strobe loads `dout` with all ones.
- R5: With `pat_sel` = 011, the first strobe after selection loads all ones. Each later strobe loads the opposite of the previous word (all zeros, then all ones, and so on).
- R6: With `pat_sel` = 100, the first strobe after selection loads 13'h1555, which is 1 in bit 12 and in every even bit. Later strobes alternate between 13'h0AAA and 13'h1555.
- R7: The pattern phase goes back to the first phase whenever `pat_sel` differs from its value at the previous clock edge. This holds even when the same pattern is selected again later.
- R8: In normal mode with `tc_en` = 1, data bit 11 is inverted.
- R9: In normal mode with `rand_en` = 1, data bits 11..1 are XORed with data bit 0. Bit 0 passes through unchanged.
- R10: In normal mode with `abp_en` = 1, data bits 1, 3, 5, 7, 9 and 11 are inverted. When several transforms are enabled they apply in this order: two's complement, then randomizer, then alternate polarity.
- R11: Whenever a pattern code (001..100) is selected, `tc_en`, `rand_en`, `abp_en`, `smp_data` and `smp_ovf` have no effect on `dout`.
- R12: The codes 101, 110 and 111 behave exactly like 000.
- R13: On the first clock edge that samples `out_dis` = 1, every bit of `dout_oe` and `clkout_oe` goes to 0. On the first clock edge that samples `out_dis` = 0, all of them go to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_data | input | 12 | Offset-binary sample from the converter core |
| smp_ovf | input | 1 | Overflow flag for the sample |
| smp_vld | input | 1 | Sample strobe, one cycle per sample |
| pat_sel | input | 3 | Test pattern select (000 = normal data) |
| tc_en | input | 1 | Two's complement enable |
| rand_en | input | 1 | Randomizer enable |
| abp_en | input | 1 | Alternate-bit polarity enable |
| out_dis | input | 1 | Output disable for data pins and clock output |
| dout | output | 13 | Registered output word, bit 12 is the overflow flag |
| dout_oe | output | 13 | Per-pin output enables for `dout` |
| clkout_oe | output | 1 | Output enable for the clock output |

## Verification
The bench stacks all three transforms on one sample. A design that applied them in another order, or fed the randomizer a bit that had already been altered, would give a different word. Pattern phase is checked across several strobes and across changes of select. A design that kept a stale phase would start the toggle or the checkerboard on the wrong half after the select came back to it. Patterns are driven together with every transform enabled and with the overflow flag set, so a formatter that let a transform leak through would corrupt a forced word. The reserved select codes, the hold on idle cycles, and the one-edge response of the enables to the disable bit are also checked.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        PAT_NORMAL  = 3'b000,
        PAT_ZEROS   = 3'b001,
        PAT_ONES    = 3'b010,
        PAT_TOGGLE  = 3'b011,
        PAT_CHECKER = 3'b100
    } pat_code_e;

endpackage

// File: rtl/fmt_data_xform.sv
module fmt_data_xform #(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic              tc_en_i,
    input  logic              rand_en_i,
    input  logic              abp_en_i,
    output logic [DATA_W-1:0] data_o
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] odd_mask;
    logic [DATA_W-1:0] stage_tc;
    logic [DATA_W-1:0] stage_rnd;

    // mask of odd-numbered bit positions
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign odd_mask[i] = (i % 2) == 1;
    end

    always_comb begin
        // step 1: offset binary to two's complement
        stage_tc      = data_i;
        stage_tc[MSB] = data_i[MSB] ^ tc_en_i;

        // step 2: scramble upper bits with the LSB
        stage_rnd = stage_tc;
        if (rand_en_i) begin
            stage_rnd[MSB:1] = stage_tc[MSB:1] ^ {(DATA_W-1){stage_tc[0]}};
        end

        // step 3: alternate polarity on odd bits
        data_o = abp_en_i ? (stage_rnd ^ odd_mask) : stage_rnd;
    end

endmodule

// File: rtl/fmt_pattern_gen.sv
module fmt_pattern_gen
    import fmt_pkg::*;
#(
    parameter int OUT_W = 13
) (
    input  logic [SEL_W-1:0] sel_i,
    input  logic             phase_i,
    output logic             active_o,
    output logic [OUT_W-1:0] word_o
);

    logic [OUT_W-1:0] chk_first;

    // first checkerboard phase: MSB set, then alternating downwards
    for (genvar i = 0; i < OUT_W; i++) begin : g_chk
        assign chk_first[i] = (i % 2) == ((OUT_W - 1) % 2);
    end

    always_comb begin
        active_o = 1'b1;
        word_o   = '0;
        case (sel_i)
            PAT_ZEROS:   word_o = '0;
            PAT_ONES:    word_o = '1;
            PAT_TOGGLE:  word_o = phase_i ? '0 : '1;
            PAT_CHECKER: word_o = phase_i ? ~chk_first : chk_first;
            default: begin
                active_o = 1'b0;
                word_o   = '0;
            end
        endcase
    end

endmodule

// File: rtl/fmt_phase_tracker.sv
module fmt_phase_tracker
    import fmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             strobe_i,
    output logic             phase_o
);

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             phase;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        // a change of select restarts the pattern at its first phase
        phase_o     = (sel_i != trk_q.sel) ? 1'b0 : trk_q.phase;
        trk_d.sel   = sel_i;
        trk_d.phase = strobe_i ? ~phase_o : phase_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '{sel: PAT_NORMAL, phase: 1'b0};
        end else begin
            trk_q <= trk_d;
        end
    end

    AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && (sel_i != trk_q.sel)) |=> trk_q.phase) // R7
        else $error("phase did not restart on new select");

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_i && (sel_i == trk_q.sel)) |=> $stable(trk_q.phase)) // R7
        else $error("phase moved without a strobe");

endmodule

// File: rtl/adc_out_formatter.sv
module adc_out_formatter
    import fmt_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_W-1:0]   smp_data,
    input  logic                smp_ovf,
    input  logic                smp_vld,
    input  logic [SEL_W-1:0]    pat_sel,
    input  logic                tc_en,
    input  logic                rand_en,
    input  logic                abp_en,
    input  logic                out_dis,
    output logic [DATA_W:0]     dout,
    output logic [DATA_W:0]     dout_oe,
    output logic                clkout_oe
);

    localparam int OUT_W = DATA_W + 1;

    typedef struct packed {
        logic [OUT_W-1:0] word;
        logic [OUT_W-1:0] oe;
        logic             clk_oe;
    } out_t;

    out_t out_d, out_q;

    logic [DATA_W-1:0] fmt_data;
    logic [OUT_W-1:0]  pat_word;
    logic              pat_active;
    logic              phase;

    fmt_data_xform #(.DATA_W(DATA_W)) u_xform (
        .data_i    (smp_data),
        .tc_en_i   (tc_en),
        .rand_en_i (rand_en),
        .abp_en_i  (abp_en),
        .data_o    (fmt_data)
    );

    fmt_phase_tracker u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (pat_sel),
        .strobe_i (smp_vld),
        .phase_o  (phase)
    );

    fmt_pattern_gen #(.OUT_W(OUT_W)) u_pat (
        .sel_i    (pat_sel),
        .phase_i  (phase),
        .active_o (pat_active),
        .word_o   (pat_word)
    );

    always_comb begin
        out_d = out_q;
        if (smp_vld) begin
            out_d.word = pat_active ? pat_word : {smp_ovf, fmt_data};
        end
        out_d.oe     = {OUT_W{~out_dis}};
        out_d.clk_oe = ~out_dis;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign dout      = out_q.word;
    assign dout_oe   = out_q.oe;
    assign clkout_oe = out_q.clk_oe;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(dout)) // R2
        else $error("output changed without strobe");

    AST_FORCE_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && pat_sel == PAT_ZEROS) |=> (dout == '0)) // R3
        else $error("zeros pattern wrong");

    AST_FORCE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && pat_sel == PAT_ONES) |=> (dout == '1)) // R4
        else $error("ones pattern wrong");

    AST_TOGGLE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && pat_sel == PAT_TOGGLE) |=> ((dout == '0) || (dout == '1))) // R5
        else $error("toggle pattern not uniform");

    AST_CHECKER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && pat_sel == PAT_CHECKER) |=> ((dout ^ {dout[OUT_W-2:0], ~dout[0]}) == '1)) // R6
        else $error("checkerboard adjacent bits equal");

    AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        out_dis |=> (dout_oe == '0 && !clkout_oe)) // R13
        else $error("enables not dropped");

    AST_OE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        !out_dis |=> (dout_oe == '1 && clkout_oe)) // R13
        else $error("enables not raised");

endmodule

// File: tb/tb_adc_out_formatter.sv
`timescale 1ns/1ps
module tb_adc_out_formatter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] smp_data = '0;
    logic        smp_ovf = 1'b0;
    logic        smp_vld = 1'b0;
    logic [2:0]  pat_sel = 3'b000;
    logic        tc_en = 1'b0;
    logic        rand_en = 1'b0;
    logic        abp_en = 1'b0;
    logic        out_dis = 1'b0;
    logic [12:0] dout;
    logic [12:0] dout_oe;
    logic        clkout_oe;

    int tests = 0;
    int fails = 0;

    logic [12:0] exp_q[$];
    string       tag_q[$];
    logic [12:0] last_exp = '0;

    logic [2:0]  m_prev = 3'b000;
    logic        m_phase = 1'b0;

    always #2 clk = ~clk;

    adc_out_formatter dut (
        .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_ovf(smp_ovf),
        .smp_vld(smp_vld), .pat_sel(pat_sel), .tc_en(tc_en), .rand_en(rand_en),
        .abp_en(abp_en), .out_dis(out_dis), .dout(dout), .dout_oe(dout_oe),
        .clkout_oe(clkout_oe)
    );

    function automatic logic [12:0] model(input logic [2:0] sel, input logic ph,
                                          input logic [11:0] d, input logic ovf,
                                          input logic tc, input logic rn, input logic ab);
        logic [11:0] v;
        case (sel)
            3'b001: return 13'h0000;
            3'b010: return 13'h1FFF;
            3'b011: return ph ? 13'h0000 : 13'h1FFF;
            3'b100: return ph ? 13'h0AAA : 13'h1555;
            default: begin
                v = d;
                if (tc) v[11] = ~v[11];
                if (rn) for (int i = 1; i < 12; i++) v[i] = v[i] ^ v[0];
                if (ab) for (int i = 1; i < 12; i += 2) v[i] = ~v[i];
                return {ovf, v};
            end
        endcase
    endfunction

    task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: one strobe, expected word pushed to the scoreboard
    task automatic send(input string tag, input logic [2:0] sel, input logic [11:0] d,
                        input logic ovf, input logic tc, input logic rn, input logic ab);
        logic eff;
        @(negedge clk);
        pat_sel = sel; smp_data = d; smp_ovf = ovf;
        tc_en = tc; rand_en = rn; abp_en = ab; smp_vld = 1'b1;
        eff = (sel != m_prev) ? 1'b0 : m_phase;
        @(posedge clk);
        last_exp = model(sel, eff, d, ovf, tc, rn, ab);
        exp_q.push_back(last_exp);
        tag_q.push_back(tag);
        m_phase = ~eff;
        m_prev = sel;
    endtask

    task automatic idle_hold(input logic [11:0] d);
        @(negedge clk);
        smp_vld = 1'b0; smp_data = d; smp_ovf = ~smp_ovf;
        @(posedge clk); #1;
        check("R2 hold", dout, last_exp);
    endtask

    task automatic set_dis(input logic v);
        @(negedge clk);
        smp_vld = 1'b0; out_dis = v;
        @(posedge clk); #1;
        check("R13 dout_oe", dout_oe, v ? 13'h0000 : 13'h1FFF);
        check("R13 clkout_oe", {12'h0, clkout_oe}, {12'h0, ~v});
    endtask

    // monitor: pops scoreboard after each edge
    initial begin
        forever begin
            @(posedge clk); #1;
            if (exp_q.size() > 0) check(tag_q.pop_front(), dout, exp_q.pop_front());
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 dout", dout, 13'h0000);
        check("R1 dout_oe", dout_oe, 13'h0000);
        check("R1 clkout_oe", {12'h0, clkout_oe}, 13'h0000);
        rst_n = 1'b1;
        set_dis(1'b0);

        send("R2 normal", 3'b000, 12'h5A3, 1'b0, 0, 0, 0);
        send("R2 normal ovf", 3'b000, 12'hF0F, 1'b1, 0, 0, 0);
        idle_hold(12'h123);
        idle_hold(12'h456);
        send("R8 twos", 3'b000, 12'h5A3, 1'b0, 1, 0, 0);
        send("R8 twos msb", 3'b000, 12'h800, 1'b1, 1, 0, 0);
        send("R9 rand lsb1", 3'b000, 12'h3C5, 1'b0, 0, 1, 0);
        send("R9 rand lsb0", 3'b000, 12'h3C4, 1'b1, 0, 1, 0);
        send("R10 abp", 3'b000, 12'h000, 1'b0, 0, 0, 1);
        send("R10 order all", 3'b000, 12'h001, 1'b1, 1, 1, 1);
        send("R10 order tc+rand", 3'b000, 12'h7FF, 1'b0, 1, 1, 0);

        send("R3 zeros", 3'b001, 12'hFFF, 1'b1, 1, 1, 1);
        send("R4 ones", 3'b010, 12'h000, 1'b0, 0, 0, 0);
        send("R11 ones xform", 3'b010, 12'h000, 1'b0, 1, 1, 1);

        send("R5 toggle 1", 3'b011, 12'hABC, 1'b0, 0, 0, 0);
        send("R5 toggle 2", 3'b011, 12'hABC, 1'b1, 1, 1, 1);
        idle_hold(12'h111);
        send("R5 toggle 3", 3'b011, 12'h000, 1'b0, 0, 0, 0);
        send("R5 toggle 4", 3'b011, 12'h000, 1'b0, 0, 0, 0);

        send("R6 checker 1", 3'b100, 12'h000, 1'b0, 0, 0, 0);
        send("R6 checker 2", 3'b100, 12'hFFF, 1'b1, 1, 0, 1);
        send("R6 checker 3", 3'b100, 12'h000, 1'b0, 0, 0, 0);

        send("R7 restart toggle", 3'b011, 12'h000, 1'b0, 0, 0, 0);
        send("R7 away", 3'b010, 12'h000, 1'b0, 0, 0, 0);
        send("R7 back toggle", 3'b011, 12'h000, 1'b0, 0, 0, 0);
        send("R7 checker new", 3'b100, 12'h000, 1'b0, 0, 0, 0);
        @(negedge clk);
        smp_vld = 1'b0; pat_sel = 3'b000;
        @(negedge clk);
        m_prev = 3'b000;
        send("R7 checker after idle", 3'b100, 12'h000, 1'b0, 0, 0, 0);

        send("R12 code5", 3'b101, 12'h5A3, 1'b1, 1, 0, 0);
        send("R12 code6", 3'b110, 12'h3C5, 1'b0, 0, 1, 0);
        send("R12 code7", 3'b111, 12'h001, 1'b1, 1, 1, 1);

        set_dis(1'b1);
        set_dis(1'b0);

        repeat (3) @(posedge clk);
        #1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule